// File: doc/BRIEF.md
# Per-Area Bus Timing Controller

This block connects a CPU core to an external memory bus that serves directly attached ROM and SRAM. The address space is divided into eight equal areas, taken from the top three address bits. Each area has its own data-bus width (8 or 16 bits), its own access length (two or three bus states) and its own count of programmed wait states. Every area has an active-low select line. A select line drives only while its direction bit is set.

The core issues an access as a one-cycle request that carries an address, a word/byte flag, a read/write flag and write data. The block captures the request and the timing of the selected area. It holds that area's select low for the whole access and drives the bus address and strobes. When the access ends, it gives the core a one-cycle ready pulse, with read data on the same cycle. A word access to an 8-bit area runs as two back-to-back byte accesses under a single select assertion.

Configuration is written through a small write port. A static mode input is sampled while reset is held and decides whether select 0 comes out of reset driving.

Top module: `bus_area_timing`

## Requirements
- R1: The area is `req_addr[23:21]`. During an access to area n, `cs_n[n]` is low and every other select is high. Outside an access, all selects are high.
- R2: `cs_oe[n]` equals the direction bit of area n. When that bit is 0, `cs_n[n]` stays high even during an access to area n, and the access still completes with ready.
- R3: While `rst_n` is low the mode input is sampled. Mode 0 resets the direction bits to 8'h01 and mode 1 resets them to 8'h00. Later changes of the mode input have no effect on `cs_oe`.
- R4: A two-state area (state bit 0) holds its select low for exactly 2 cycles per byte access. Its wait bits are ignored.
- R5: A three-state area (state bit 1) with wait value w holds its select low for 3+w cycles per byte access.
- R6: A word access to a 16-bit area (width bit 0) is a single access, and `rdata` equals `ext_rdata` as sampled in the final state.
- R7: A word access to an 8-bit area (width bit 1) runs two byte accesses. The first uses the even address (bit 0 cleared) and the second the odd address. The select stays low across both, and ready follows only the second. The read result is {first byte, second byte}, each byte taken from `ext_rdata[7:0]`.
- R8: `ready` is high for exactly one cycle: the cycle after the last bus state, when all selects are high again.
- R9: After reset, every area is 16-bit, three-state, with 3 wait states, so a word access takes 6 bus cycles.
- R10: A `cfg_we` write sets one bit per area (bit n = area n) in the field chosen by `cfg_sel`: 0 width, 1 state, 2 wait bit 1, 3 wait bit 0, 4 direction. Values 5 to 7 change nothing.
- R11: `ext_rd_n` is low in every state of a read. `ext_wr_n` is low in every state of a write except the first state of each byte access. The two are never low together.
- R12: A byte read returns data in `rdata[7:0]` with `rdata[15:8]` zero. A 16-bit area uses lane [15:8] for an even address and lane [7:0] for an odd one. An 8-bit area uses [7:0]. A write drives the selected byte on both lanes of `ext_wdata`, except for a word write to a 16-bit area, which drives the full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_on_mode | input | 1 | Static mode input, sampled during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_data | input | 8 | One bit per area for the selected field |
| req | input | 1 | One-cycle access request, taken when idle |
| req_addr | input | 24 | Access address |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ready |
| cs_n | output | 8 | Active-low area selects |
| cs_oe | output | 8 | Per-select output enable (direction) |
| ext_addr | output | 24 | Bus address |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_wdata | output | 16 | Bus write data |
| ext_rdata | input | 16 | Bus read data |

## Verification
The bench checks every configured access length. This includes a two-state area holding wait value 3, where a design that honoured the wait bits would stretch the select to 5 cycles. It runs split word accesses to 8-bit areas, in both two-state and three-state areas, to catch byte order swapped, the select releasing between the halves, or ready arriving after the first half. It also checks byte lanes on 16-bit areas for odd and even addresses, selects masked by a cleared direction bit, writes with an unused field select, and the reset direction values under both modes. A later mode change is also covered, which a design that read the mode input continuously would follow.

// File: rtl/bat_pkg.sv
package bat_pkg;
    localparam int BAT_DATA_W = 16;
    localparam int BAT_BYTE_W = 8;

    // Timing captured for the area of one access
    typedef struct packed {
        logic       narrow;  // 1: 8-bit bus
        logic       three;   // 1: three-state access
        logic [1:0] waits;   // programmed wait states
    } area_cfg_t;

    localparam logic [2:0] SEL_WIDTH  = 3'd0;
    localparam logic [2:0] SEL_STATES = 3'd1;
    localparam logic [2:0] SEL_WAIT1  = 3'd2;
    localparam logic [2:0] SEL_WAIT0  = 3'd3;
    localparam logic [2:0] SEL_DIR    = 3'd4;
endpackage

// File: rtl/bat_cfg.sv
module bat_cfg #(
    parameter int N_AREAS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rom_on_mode,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [N_AREAS-1:0] cfg_data,
    output logic [N_AREAS-1:0] narrow,
    output logic [N_AREAS-1:0] three,
    output logic [N_AREAS-1:0] wait_hi,
    output logic [N_AREAS-1:0] wait_lo,
    output logic [N_AREAS-1:0] dir
);
    import bat_pkg::*;

    typedef struct packed {
        logic [N_AREAS-1:0] narrow;
        logic [N_AREAS-1:0] three;
        logic [N_AREAS-1:0] wait_hi;
        logic [N_AREAS-1:0] wait_lo;
        logic [N_AREAS-1:0] dir;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    cfg_t cfg_rst;

    always_comb begin
        cfg_rst         = '0;
        cfg_rst.narrow  = '0;
        cfg_rst.three   = '1;
        cfg_rst.wait_hi = '1;
        cfg_rst.wait_lo = '1;
        cfg_rst.dir     = rom_on_mode ? '0 : N_AREAS'(1);
    end

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_WIDTH:  cfg_d.narrow  = cfg_data;
                SEL_STATES: cfg_d.three   = cfg_data;
                SEL_WAIT1:  cfg_d.wait_hi = cfg_data;
                SEL_WAIT0:  cfg_d.wait_lo = cfg_data;
                SEL_DIR:    cfg_d.dir     = cfg_data;
                default:    cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_rst;
        else        cfg_q <= cfg_d;
    end

    assign narrow  = cfg_q.narrow;
    assign three   = cfg_q.three;
    assign wait_hi = cfg_q.wait_hi;
    assign wait_lo = cfg_q.wait_lo;
    assign dir     = cfg_q.dir;
endmodule

// File: rtl/bat_area_dec.sv
module bat_area_dec #(
    parameter int N_AREAS = 8,
    localparam int AREA_W = $clog2(N_AREAS)
) (
    input  logic [AREA_W-1:0]  area,
    input  logic               en,
    output logic [N_AREAS-1:0] hit
);
    for (genvar i = 0; i < N_AREAS; i++) begin : g_hit
        assign hit[i] = en && (area == AREA_W'(i));
    end
endmodule

// File: rtl/bat_seq.sv
module bat_seq #(
    parameter int ADDR_W  = 24,
    parameter int N_AREAS = 8,
    localparam int AREA_W = $clog2(N_AREAS),
    localparam int DW     = bat_pkg::BAT_DATA_W,
    localparam int BW     = bat_pkg::BAT_BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_word,
    input  logic                  req_write,
    input  logic [DW-1:0]         req_wdata,
    input  bat_pkg::area_cfg_t    req_cfg,
    input  logic [DW-1:0]         ext_rdata,
    output logic                  busy,
    output logic [AREA_W-1:0]     area,
    output logic                  ready,
    output logic [DW-1:0]         rdata,
    output logic [ADDR_W-1:0]     ext_addr,
    output logic                  ext_rd_n,
    output logic                  ext_wr_n,
    output logic [DW-1:0]         ext_wdata
);
    typedef struct packed {
        logic              busy;
        logic [AREA_W-1:0] area;
        logic              narrow;
        logic              three;
        logic [1:0]        waits;
        logic              split;
        logic              second;
        logic [2:0]        phase;
        logic              write;
        logic              word;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     wdata;
        logic [DW-1:0]     rdata;
        logic              ready;
    } seq_t;

    seq_t s_d, s_q;
    logic [2:0]    last_phase;
    logic [BW-1:0] wr_byte;

    assign last_phase = s_q.three ? (3'd2 + {1'b0, s_q.waits}) : 3'd1;

    always_comb begin
        s_d       = s_q;
        s_d.ready = 1'b0;
        if (!s_q.busy) begin
            if (req) begin
                s_d.busy   = 1'b1;
                s_d.area   = req_addr[ADDR_W-1 -: AREA_W];
                s_d.narrow = req_cfg.narrow;
                s_d.three  = req_cfg.three;
                s_d.waits  = req_cfg.three ? req_cfg.waits : 2'd0;
                s_d.split  = req_word && req_cfg.narrow;
                s_d.second = 1'b0;
                s_d.phase  = '0;
                s_d.write  = req_write;
                s_d.word   = req_word;
                s_d.addr   = req_addr;
                s_d.wdata  = req_wdata;
            end
        end else if (s_q.phase == last_phase) begin
            if (s_q.split) begin
                if (s_q.second) s_d.rdata[BW-1:0]  = ext_rdata[BW-1:0];
                else            s_d.rdata[DW-1:BW] = ext_rdata[BW-1:0];
            end else if (s_q.narrow) begin
                s_d.rdata = {{BW{1'b0}}, ext_rdata[BW-1:0]};
            end else if (s_q.word) begin
                s_d.rdata = ext_rdata;
            end else begin
                s_d.rdata = {{BW{1'b0}},
                             s_q.addr[0] ? ext_rdata[BW-1:0] : ext_rdata[DW-1:BW]};
            end
            if (s_q.split && !s_q.second) begin
                s_d.second = 1'b1;
                s_d.phase  = '0;
            end else begin
                s_d.busy  = 1'b0;
                s_d.ready = 1'b1;
            end
        end else begin
            s_d.phase = s_q.phase + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_byte   = (s_q.split && !s_q.second) ? s_q.wdata[DW-1:BW] : s_q.wdata[BW-1:0];
    assign busy      = s_q.busy;
    assign area      = s_q.area;
    assign ready     = s_q.ready;
    assign rdata     = s_q.rdata;
    assign ext_addr  = s_q.split ? {s_q.addr[ADDR_W-1:1], s_q.second} : s_q.addr;
    assign ext_rd_n  = !(s_q.busy && !s_q.write);
    assign ext_wr_n  = !(s_q.busy && s_q.write && (s_q.phase != 3'd0));
    assign ext_wdata = (s_q.word && !s_q.narrow) ? s_q.wdata : {wr_byte, wr_byte};
endmodule

// File: rtl/bus_area_timing.sv
module bus_area_timing #(
    parameter int ADDR_W  = 24,
    parameter int N_AREAS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rom_on_mode,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [N_AREAS-1:0] cfg_data,
    input  logic               req,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_word,
    input  logic               req_write,
    input  logic [15:0]        req_wdata,
    output logic               ready,
    output logic [15:0]        rdata,
    output logic [N_AREAS-1:0] cs_n,
    output logic [N_AREAS-1:0] cs_oe,
    output logic [ADDR_W-1:0]  ext_addr,
    output logic               ext_rd_n,
    output logic               ext_wr_n,
    output logic [15:0]        ext_wdata,
    input  logic [15:0]        ext_rdata
);
    import bat_pkg::*;
    localparam int AREA_W = $clog2(N_AREAS);

    logic [N_AREAS-1:0] narrow, three, wait_hi, wait_lo, dir;
    logic [AREA_W-1:0]  req_area, cur_area;
    logic               busy;
    logic [N_AREAS-1:0] hit;
    area_cfg_t          sel_cfg;

    bat_cfg #(.N_AREAS(N_AREAS)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .rom_on_mode (rom_on_mode),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_data    (cfg_data),
        .narrow      (narrow),
        .three       (three),
        .wait_hi     (wait_hi),
        .wait_lo     (wait_lo),
        .dir         (dir)
    );

    assign req_area       = req_addr[ADDR_W-1 -: AREA_W];
    assign sel_cfg.narrow = narrow[req_area];
    assign sel_cfg.three  = three[req_area];
    assign sel_cfg.waits  = {wait_hi[req_area], wait_lo[req_area]};

    bat_seq #(.ADDR_W(ADDR_W), .N_AREAS(N_AREAS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_addr  (req_addr),
        .req_word  (req_word),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .req_cfg   (sel_cfg),
        .ext_rdata (ext_rdata),
        .busy      (busy),
        .area      (cur_area),
        .ready     (ready),
        .rdata     (rdata),
        .ext_addr  (ext_addr),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n),
        .ext_wdata (ext_wdata)
    );

    bat_area_dec #(.N_AREAS(N_AREAS)) u_dec (
        .area (cur_area),
        .en   (busy),
        .hit  (hit)
    );

    assign cs_n  = ~(hit & dir);
    assign cs_oe = dir;
endmodule

// File: rtl/bus_area_timing_chk.sv
module bus_area_timing_chk #(
    parameter int N_AREAS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rom_on_mode,
    input logic               ready,
    input logic [N_AREAS-1:0] cs_n,
    input logic [N_AREAS-1:0] cs_oe,
    input logic               ext_rd_n,
    input logic               ext_wr_n
);
    p_single_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_cs_needs_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((~cs_n) & (~cs_oe)) == '0);

    p_dir_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cs_oe == ($past(rom_on_mode) ? '0 : N_AREAS'(1))));

    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ((&cs_n) && ext_rd_n && ext_wr_n));

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));
endmodule

bind bus_area_timing bus_area_timing_chk #(.N_AREAS(N_AREAS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rom_on_mode (rom_on_mode),
    .ready       (ready),
    .cs_n        (cs_n),
    .cs_oe       (cs_oe),
    .ext_rd_n    (ext_rd_n),
    .ext_wr_n    (ext_wr_n)
);

// File: tb/bus_area_timing_test.sv
`timescale 1ns/1ps
module bus_area_timing_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rom_on_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_data = '0;
    logic        req = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        ready;
    logic [15:0] rdata;
    logic [7:0]  cs_n, cs_oe;
    logic [23:0] ext_addr;
    logic        ext_rd_n, ext_wr_n;
    logic [15:0] ext_wdata, ext_rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    function automatic logic [15:0] mem16(input logic [23:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] ^ a[7:0] ^ 8'h3C};
    endfunction

    assign ext_rdata = mem16(ext_addr);

    bus_area_timing uut (
        .clk(clk), .rst_n(rst_n), .rom_on_mode(rom_on_mode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .req(req), .req_addr(req_addr), .req_word(req_word),
        .req_write(req_write), .req_wdata(req_wdata),
        .ready(ready), .rdata(rdata), .cs_n(cs_n), .cs_oe(cs_oe),
        .ext_addr(ext_addr), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    // ---------------- reference model ----------------
    int          m_nar[8], m_thr[8], m_wt[8];
    logic [7:0]  m_dir;
    logic        m_busy, m_ready, m_split, m_write, m_word, m_narrow;
    int          m_k, m_len, m_per, m_area;
    logic [23:0] m_addr;
    logic [15:0] m_wdata, m_rdata;

    function automatic logic [15:0] exp_read(input logic [23:0] a, input logic w, input logic nar);
        logic [15:0] v0, v1;
        v0 = mem16({a[23:1], 1'b0});
        v1 = mem16({a[23:1], 1'b1});
        if (w && nar) return {v0[7:0], v1[7:0]};
        v0 = mem16(a);
        if (nar) return {8'h00, v0[7:0]};
        if (w)   return v0;
        return {8'h00, a[0] ? v0[7:0] : v0[15:8]};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        m_ready <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_nar[i] <= 0; m_thr[i] <= 1; m_wt[i] <= 3;
            end
            m_dir  <= rom_on_mode ? 8'h00 : 8'h01;
            m_busy <= 1'b0;
        end else begin
            if (cfg_we) begin
                for (int i = 0; i < 8; i++) begin
                    case (cfg_sel)
                        3'd0: m_nar[i] <= int'(cfg_data[i]);
                        3'd1: m_thr[i] <= int'(cfg_data[i]);
                        3'd2: m_wt[i]  <= (m_wt[i] % 2) + 2 * int'(cfg_data[i]);
                        3'd3: m_wt[i]  <= (m_wt[i] / 2) * 2 + int'(cfg_data[i]);
                        default: ;
                    endcase
                end
                if (cfg_sel == 3'd4) m_dir <= cfg_data;
            end
            if (!m_busy && req) begin
                int a, per;
                a   = int'(req_addr[23:21]);
                per = (m_thr[a] != 0) ? 3 + m_wt[a] : 2;
                m_area   <= a;
                m_per    <= per;
                m_split  <= req_word && (m_nar[a] != 0);
                m_narrow <= (m_nar[a] != 0);
                m_len    <= (req_word && (m_nar[a] != 0)) ? 2 * per : per;
                m_k      <= 0;
                m_busy   <= 1'b1;
                m_addr   <= req_addr;
                m_word   <= req_word;
                m_write  <= req_write;
                m_wdata  <= req_wdata;
            end else if (m_busy) begin
                if (m_k == m_len - 1) begin
                    m_busy  <= 1'b0;
                    m_ready <= 1'b1;
                    m_rdata <= exp_read(m_addr, m_word, m_narrow);
                end else begin
                    m_k <= m_k + 1;
                end
            end
        end
    end

    logic [7:0]  e_cs;
    logic        e_rd, e_wr;
    logic [23:0] e_addr;
    logic [15:0] e_wd;
    always_comb begin
        int b, j;
        logic [7:0] by;
        e_cs = 8'hFF; e_rd = 1'b1; e_wr = 1'b1; e_addr = '0; e_wd = '0;
        b = 0; j = 0; by = '0;
        if (m_busy) begin
            b = m_k / m_per;
            j = m_k % m_per;
            if (m_dir[m_area]) e_cs = ~(8'h01 << m_area);
            e_rd   = m_write;
            e_wr   = !(m_write && j != 0);
            e_addr = m_split ? {m_addr[23:1], b[0]} : m_addr;
            by     = (m_split && b == 0) ? m_wdata[15:8] : m_wdata[7:0];
            e_wd   = (m_word && !m_narrow) ? m_wdata : {by, by};
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 R2 cs_n", {24'h0, cs_n}, {24'h0, e_cs});
            chk("R3 cs_oe", {24'h0, cs_oe}, {24'h0, m_dir});
            chk("R8 ready", {31'h0, ready}, {31'h0, m_ready});
            chk("R11 strobes", {30'h0, ext_rd_n, ext_wr_n}, {30'h0, e_rd, e_wr});
            if (m_busy) chk("R7 ext_addr", {8'h0, ext_addr}, {8'h0, e_addr});
            if (m_busy && m_write) chk("R12 ext_wdata", {16'h0, ext_wdata}, {16'h0, e_wd});
            if (m_ready && !m_write) chk("R6 R12 rdata", {16'h0, rdata}, {16'h0, m_rdata});
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        rom_on_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [7:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic acc(input int area, input logic [20:0] lo, input logic word, input logic wr,
                       input logic [15:0] wd, input int exp_len, input string tag);
        int n;
        req = 1'b1; req_addr = {area[2:0], lo}; req_word = word;
        req_write = wr; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        n = 1;
        while (!ready && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " access length"}, n - 1, exp_len);
        @(negedge clk);
    endtask

    initial begin
        do_reset(1'b0);
        // R9: reset timing, 16-bit three-state with 3 waits
        acc(0, 21'h012344, 1'b1, 1'b0, 16'h0, 6, "R9");
        // R2: area 3 select not driven after reset, access still completes
        acc(3, 21'h000010, 1'b1, 1'b0, 16'h0, 6, "R2");
        // R10: configure all fields
        cfg_write(3'd4, 8'hFF);
        cfg_write(3'd1, 8'b0111_1101);
        cfg_write(3'd2, 8'b1111_0011);
        cfg_write(3'd3, 8'b1110_1011);
        cfg_write(3'd0, 8'b1100_0000);
        // R4: two-state area holding wait value 3
        acc(1, 21'h000100, 1'b1, 1'b0, 16'h0, 2, "R4");
        acc(1, 21'h000102, 1'b1, 1'b1, 16'hBEEF, 2, "R4");
        // R5: three-state areas with 0..3 waits
        acc(2, 21'h000200, 1'b1, 1'b0, 16'h0, 3, "R5");
        acc(3, 21'h000300, 1'b1, 1'b0, 16'h0, 4, "R5");
        acc(4, 21'h000400, 1'b1, 1'b1, 16'h1234, 5, "R5");
        acc(5, 21'h000500, 1'b1, 1'b1, 16'hA5C3, 6, "R5");
        // R6: word read in a 16-bit area
        acc(0, 21'h00ABCE, 1'b1, 1'b0, 16'h0, 6, "R6");
        // R7: split accesses in 8-bit areas
        acc(6, 21'h000611, 1'b1, 1'b0, 16'h0, 12, "R7");
        acc(7, 21'h000700, 1'b1, 1'b1, 16'hC0DE, 4, "R7");
        acc(7, 21'h000733, 1'b1, 1'b0, 16'h0, 4, "R7");
        // R12: byte accesses
        acc(6, 21'h000655, 1'b0, 1'b0, 16'h0, 6, "R12");
        acc(0, 21'h000044, 1'b0, 1'b0, 16'h0, 6, "R12");
        acc(0, 21'h000045, 1'b0, 1'b0, 16'h0, 6, "R12");
        acc(0, 21'h000046, 1'b0, 1'b1, 16'h9977, 6, "R12");
        // R10: unused field selects change nothing
        cfg_write(3'd7, 8'h00);
        cfg_write(3'd5, 8'h00);
        acc(2, 21'h000208, 1'b1, 1'b0, 16'h0, 3, "R10");
        acc(6, 21'h000610, 1'b1, 1'b0, 16'h0, 12, "R10");
        // R2: direction cleared for area 5
        cfg_write(3'd4, 8'b1101_1111);
        acc(5, 21'h000504, 1'b1, 1'b0, 16'h0, 6, "R2");
        // R3: mode 1 reset, then mode changes after reset
        do_reset(1'b1);
        chk("R3 reset oe mode1", {24'h0, cs_oe}, 32'h0);
        rom_on_mode = 1'b0;
        repeat (4) @(negedge clk);
        chk("R3 oe after mode change", {24'h0, cs_oe}, 32'h0);
        acc(0, 21'h000020, 1'b1, 1'b0, 16'h0, 6, "R3");
        do_reset(1'b0);
        chk("R3 reset oe mode0", {24'h0, cs_oe}, 32'h1);
        acc(0, 21'h000022, 1'b1, 1'b1, 16'h4321, 6, "R1");
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule